// File: doc/BRIEF.md
# EDO DRAM Device Access Logic

A cycle-sampled behavioural model of the access logic found inside an asynchronous DRAM with extended-data-out page mode. Every strobe (row strobe, lower and upper column strobes, write enable and output enable, all active low) is sampled on a fast system clock. Edges are found by comparing each sample with the one before. A small on-chip array stands in for the cell matrix. The row address is taken when the row strobe falls, and a column address is taken on each column strobe fall, so several columns can be accessed within one open page.

Each byte lane has its own access type, set by when write enable falls relative to that lane's column strobe. If write enable is already low when the column strobe falls, the lane does an early write and stays off the bus. If write enable falls later, the lane does a late write, but only when output enable is high. With output enable low, the write is refused and the lane keeps driving read data. Read data stays on the bus after the column strobe rises. A lane never drives a floating bus; instead, each lane reports through its own output-enable bit whether it is driving.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, no lane drives, the mix error flag is low, and every array location reads back as zero.
- R2: The row is taken on the row strobe fall and the column on a column strobe fall while the row strobe is low. With write enable high and output enable low, the lane drives the stored byte of that location from the cycle after its column strobe fall.
- R3: When write enable is low at a lane's column strobe fall, the lane stores its byte of dq_i in that cycle (early write), and it does not drive while its column strobe stays low, whatever output enable is.
- R4: When write enable falls while a lane is reading with its column strobe low and output enable high, the lane stores its byte of dq_i at the column latched at the strobe fall (late write), and it does not drive.
- R5: When write enable falls while a lane is reading with output enable low, nothing is stored, and the lane keeps driving the previously read byte.
- R6: Lane 0 is bits 7:0 with column strobe casl_ni and dq_oe_o[0]. Lane 1 is bits 15:8 with cash_ni and dq_oe_o[1]. A write touches only the lanes whose column strobe it used.
- R7: After a reading lane's column strobe rises, the lane keeps driving the same data while the row strobe and output enable stay low and write enable stays high.
- R8: A held lane stops driving if output enable goes high or write enable goes low, and it does not resume when that input returns. No lane drives while the row strobe is high.
- R9: While both the row and column strobes are low on a reading lane, taking output enable high stops the drive and taking it low again restores the same data.
- R10: A late write attempted on one lane while the other lane holds an early write in the same strobe period raises mix_err_o, and the late byte is not stored. An early write on one lane while the other lane holds a late write also raises the flag. The flag stays set until the next row strobe fall clears it.
- R11: Once the early-writing lane's column strobe has risen, a late write on the other lane is stored and raises no error.
- R12: Several column accesses (writes and reads) to different columns within one row-strobe-low page each reach their own location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Lower byte column strobe, active low |
| cash_ni | input | 1 | Upper byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus |
| dq_oe_o | output | 2 | Per-lane drive enable (bit 0 lower, bit 1 upper) |
| mix_err_o | output | 1 | Sticky flag for an illegal early/late mix in one strobe period |

## Verification
Writes are applied with write enable falling before the column strobe, after it with output enable high, and after it with output enable low. Reading each location back afterwards shows which timing actually stores data. Single-lane and dual-lane strobes show whether byte masking is correct. Column-strobe-high hold sequences are ended by output enable, by write enable and by the row strobe, which separates the extended-data-out hold from ordinary output-enable gating while the column strobe is low. The mixed early/late sequence is run both with and without an intervening column precharge, which tells a real lane conflict from two legal writes.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int DQ_W   = LANES * BYTE_W;

  // strobe vector bit positions
  localparam int S_RAS  = 0;
  localparam int S_CASL = 1;
  localparam int S_CASH = 2;
  localparam int S_WE   = 3;
  localparam int S_OE   = 4;
  localparam int S_N    = 5;

  typedef enum logic [2:0] {
    LN_IDLE,
    LN_READ,
    LN_HOLD,
    LN_EARLY,
    LN_LATE
  } lane_st_e;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_ni,
  output logic [N-1:0] low_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_ni;
  end

  assign low_o  = ~lvl_ni;
  assign fall_o = prev_q & ~lvl_ni;
  assign rise_o = ~prev_q & lvl_ni;
endmodule

// File: rtl/edo_array.sv
module edo_array import edo_pkg::*; #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [COL_W-1:0]            rd_col_i,
  output logic [LANES-1:0][BYTE_W-1:0] rd_data_o,
  input  logic [LANES-1:0]            wr_en_i,
  input  logic [LANES-1:0][COL_W-1:0] wr_col_i,
  input  logic [LANES-1:0][BYTE_W-1:0] wr_data_i
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DQ_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_en_i[b]) mem_q[{row_i, wr_col_i[b]}][b*BYTE_W +: BYTE_W] <= wr_data_i[b];
      end
    end
  end

  logic [DQ_W-1:0] rd_word;
  assign rd_word = mem_q[{row_i, rd_col_i}];

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_data_o[g] = rd_word[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl import edo_pkg::*; #(
  parameter int COL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_low_i,
  input  logic              cas_low_i,
  input  logic              cas_fall_i,
  input  logic              cas_rise_i,
  input  logic              we_low_i,
  input  logic              we_fall_i,
  input  logic              oe_low_i,
  input  logic              other_early_i,
  input  logic              other_late_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              drive_o,
  output logic [BYTE_W-1:0] q_o,
  output logic              early_o,
  output logic              late_o,
  output logic              err_o,
  output logic              wr_en_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  lane_st_e          st_q, st_d;
  logic [COL_W-1:0]  col_q;
  logic [BYTE_W-1:0] q_q;

  logic open_fall, early_go, late_try, late_ok;

  assign open_fall = ras_low_i && cas_fall_i;
  assign early_go  = open_fall && we_low_i;
  assign late_try  = (st_q == LN_READ) && ras_low_i && cas_low_i && we_fall_i && !oe_low_i;
  assign late_ok   = late_try && !other_early_i;

  assign err_o     = (late_try && other_early_i) || (early_go && other_late_i);
  assign wr_en_o   = early_go || late_ok;
  assign wr_col_o  = early_go ? col_i : col_q;
  assign wr_data_o = wdata_i;

  assign drive_o = ((st_q == LN_READ) || (st_q == LN_HOLD)) && oe_low_i && ras_low_i;
  assign q_o     = q_q;
  assign early_o = (st_q == LN_EARLY);
  assign late_o  = (st_q == LN_LATE);

  always_comb begin
    st_d = st_q;
    if (!ras_low_i) begin
      st_d = LN_IDLE;
    end else if (open_fall) begin
      st_d = we_low_i ? LN_EARLY : LN_READ;
    end else begin
      unique case (st_q)
        LN_READ: begin
          if (cas_rise_i)    st_d = (oe_low_i && !we_low_i) ? LN_HOLD : LN_IDLE;
          else if (late_try) st_d = LN_LATE;
        end
        LN_EARLY, LN_LATE: if (cas_rise_i) st_d = LN_IDLE;
        LN_HOLD: if (!oe_low_i || we_low_i) st_d = LN_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LN_IDLE;
      col_q <= '0;
      q_q   <= '0;
    end else begin
      st_q <= st_d;
      if (open_fall) col_q <= col_i;
      if (open_fall && !we_low_i) q_q <= rdata_i;
    end
  end

  // R3: an early-write strobe never puts the lane on the bus
  p_early_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall_i && ras_low_i && we_low_i) |=> !drive_o);

  // R5: refused read-modify-write stores nothing
  p_rmw_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == LN_READ) && cas_low_i && we_fall_i && oe_low_i) |-> !wr_en_o);

  // R4: one store per column strobe period
  p_single_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model import edo_pkg::*; #(
  parameter  int ROW_W  = 4,
  parameter  int COL_W  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              casl_ni,
  input  logic              cash_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [LANES-1:0]  dq_oe_o,
  output logic              mix_err_o
);
  logic [S_N-1:0] stb_low, stb_fall, stb_rise;

  edo_strobe_edges #(.N(S_N)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_ni ({oe_ni, we_ni, cash_ni, casl_ni, ras_ni}),
    .low_o  (stb_low),
    .fall_o (stb_fall),
    .rise_o (stb_rise)
  );

  logic [ROW_W-1:0] row_q;
  logic             mix_err_q;

  logic [LANES-1:0]              ln_drive, ln_early, ln_late, ln_err, ln_wr_en;
  logic [LANES-1:0][BYTE_W-1:0]  ln_q, ln_wr_data, ln_rdata;
  logic [LANES-1:0][COL_W-1:0]   ln_wr_col;

  edo_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_i     (row_q),
    .rd_col_i  (addr_i[COL_W-1:0]),
    .rd_data_o (ln_rdata),
    .wr_en_i   (ln_wr_en),
    .wr_col_i  (ln_wr_col),
    .wr_data_i (ln_wr_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int OTH = LANES - 1 - g;
    edo_lane_ctrl #(.COL_W(COL_W)) u_lane (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ras_low_i     (stb_low[S_RAS]),
      .cas_low_i     (stb_low[S_CASL+g]),
      .cas_fall_i    (stb_fall[S_CASL+g]),
      .cas_rise_i    (stb_rise[S_CASL+g]),
      .we_low_i      (stb_low[S_WE]),
      .we_fall_i     (stb_fall[S_WE]),
      .oe_low_i      (stb_low[S_OE]),
      .other_early_i (ln_early[OTH]),
      .other_late_i  (ln_late[OTH]),
      .col_i         (addr_i[COL_W-1:0]),
      .wdata_i       (dq_i[g*BYTE_W +: BYTE_W]),
      .rdata_i       (ln_rdata[g]),
      .drive_o       (ln_drive[g]),
      .q_o           (ln_q[g]),
      .early_o       (ln_early[g]),
      .late_o        (ln_late[g]),
      .err_o         (ln_err[g]),
      .wr_en_o       (ln_wr_en[g]),
      .wr_col_o      (ln_wr_col[g]),
      .wr_data_o     (ln_wr_data[g])
    );
    assign dq_o[g*BYTE_W +: BYTE_W] = ln_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q     <= '0;
      mix_err_q <= 1'b0;
    end else begin
      if (stb_fall[S_RAS]) row_q <= addr_i[ROW_W-1:0];
      // a new page clears the flag; a fresh conflict still wins
      if (|ln_err)              mix_err_q <= 1'b1;
      else if (stb_fall[S_RAS]) mix_err_q <= 1'b0;
    end
  end

  assign dq_oe_o   = ln_drive;
  assign mix_err_o = mix_err_q;

  p_oe_high_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (dq_oe_o == '0));

  p_ras_high_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_ni |-> (dq_oe_o == '0));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mix_err_o && !(ras_ni == 1'b0 && $past(ras_ni) == 1'b1)) |=> mix_err_o);
endmodule

// File: tb/edo_dram_model_tb.sv
module edo_dram_model_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ras_ni = 1'b1, casl_ni = 1'b1, cash_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [3:0]  addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic        mix_err_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  edo_dram_model u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .casl_ni(casl_ni), .cash_ni(cash_ni),
    .we_ni(we_ni), .oe_ni(oe_ni), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .mix_err_o(mix_err_o)
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    ras_ni = 1'b1; casl_ni = 1'b1; cash_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
    tick();
  endtask

  task automatic open_row(input logic [3:0] r);
    ras_ni = 1'b0; addr_i = r; tick();
  endtask

  task automatic release_cas();
    casl_ni = 1'b1; cash_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1; tick();
  endtask

  task automatic early_wr(input logic [1:0] lanes, input logic [3:0] col, input logic [15:0] d);
    we_ni = 1'b0; dq_i = d; addr_i = col;
    casl_ni = ~lanes[0]; cash_ni = ~lanes[1]; tick();
    release_cas();
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] col, input logic [15:0] exp);
    we_ni = 1'b1; oe_ni = 1'b0; addr_i = col; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    chk({tag, " oe"}, {14'd0, dq_oe_o}, 16'h0003);
    chk({tag, " data"}, dq_o, exp);
    release_cas();
  endtask

  task automatic t_reset();
    chk("R1 idle drive", {14'd0, dq_oe_o}, 16'h0);
    chk("R1 idle err", {15'd0, mix_err_o}, 16'h0);
    open_row(4'd3);
    rd_chk("R1 zero array", 4'd5, 16'h0000);
    idle_all();
  endtask

  task automatic t_early();
    open_row(4'd2);
    oe_ni = 1'b0; we_ni = 1'b0; dq_i = 16'hA5C3; addr_i = 4'd1; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    chk("R3 early hiz with oe low", {14'd0, dq_oe_o}, 16'h0);
    tick();
    chk("R3 early hiz held", {14'd0, dq_oe_o}, 16'h0);
    release_cas();
    rd_chk("R2 R3 readback", 4'd1, 16'hA5C3);
    early_wr(2'b01, 4'd1, 16'h1234);
    rd_chk("R6 lower only", 4'd1, 16'hA534);
    early_wr(2'b10, 4'd1, 16'h7799);
    rd_chk("R6 upper only", 4'd1, 16'h7734);
    idle_all();
  endtask

  task automatic t_late();
    open_row(4'd4);
    oe_ni = 1'b1; we_ni = 1'b1; addr_i = 4'd7; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    addr_i = 4'd0; we_ni = 1'b0; dq_i = 16'hBEEF; tick();
    chk("R4 late hiz", {14'd0, dq_oe_o}, 16'h0);
    release_cas();
    rd_chk("R4 late readback", 4'd7, 16'hBEEF);
    idle_all();
  endtask

  task automatic t_rmw_blocked();
    open_row(4'd4);
    oe_ni = 1'b0; we_ni = 1'b1; addr_i = 4'd7; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    we_ni = 1'b0; dq_i = 16'h0000; tick();
    chk("R5 still driving", {14'd0, dq_oe_o}, 16'h0003);
    chk("R5 read data", dq_o, 16'hBEEF);
    release_cas();
    rd_chk("R5 no write", 4'd7, 16'hBEEF);
    idle_all();
  endtask

  task automatic t_hold();
    open_row(4'd4);
    oe_ni = 1'b0; we_ni = 1'b1; addr_i = 4'd7; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    casl_ni = 1'b1; cash_ni = 1'b1; tick(); tick();
    chk("R7 hold drive", {14'd0, dq_oe_o}, 16'h0003);
    chk("R7 hold data", dq_o, 16'hBEEF);
    oe_ni = 1'b1; tick();
    chk("R8 oe ends hold", {14'd0, dq_oe_o}, 16'h0);
    oe_ni = 1'b0; tick();
    chk("R8 no resume", {14'd0, dq_oe_o}, 16'h0);
    casl_ni = 1'b0; cash_ni = 1'b0; addr_i = 4'd7; tick();
    casl_ni = 1'b1; cash_ni = 1'b1; tick();
    we_ni = 1'b0; tick();
    chk("R8 we ends hold", {14'd0, dq_oe_o}, 16'h0);
    we_ni = 1'b1; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    casl_ni = 1'b1; cash_ni = 1'b1; tick();
    ras_ni = 1'b1; tick();
    chk("R8 ras high hiz", {14'd0, dq_oe_o}, 16'h0);
    idle_all();
  endtask

  task automatic t_oe_toggle();
    open_row(4'd2);
    oe_ni = 1'b0; we_ni = 1'b1; addr_i = 4'd1; casl_ni = 1'b0; cash_ni = 1'b0; tick();
    oe_ni = 1'b1; tick();
    chk("R9 oe high hiz", {14'd0, dq_oe_o}, 16'h0);
    oe_ni = 1'b0; tick();
    chk("R9 oe low drive", {14'd0, dq_oe_o}, 16'h0003);
    chk("R9 same data", dq_o, 16'h7734);
    idle_all();
  endtask

  task automatic t_page();
    open_row(4'd6);
    early_wr(2'b11, 4'd0, 16'h1111);
    early_wr(2'b11, 4'd3, 16'h3333);
    rd_chk("R12 page col0", 4'd0, 16'h1111);
    rd_chk("R12 page col3", 4'd3, 16'h3333);
    idle_all();
  endtask

  task automatic t_mixed();
    open_row(4'd8);
    we_ni = 1'b0; dq_i = 16'h00AA; addr_i = 4'd2; casl_ni = 1'b0; tick();
    we_ni = 1'b1; tick();
    oe_ni = 1'b1; cash_ni = 1'b0; addr_i = 4'd2; tick();
    we_ni = 1'b0; dq_i = 16'hCC00; tick();
    chk("R10 err set", {15'd0, mix_err_o}, 16'h1);
    release_cas();
    chk("R10 err sticky", {15'd0, mix_err_o}, 16'h1);
    idle_all();
    chk("R10 err kept with ras high", {15'd0, mix_err_o}, 16'h1);
    open_row(4'd8);
    chk("R10 err cleared on ras fall", {15'd0, mix_err_o}, 16'h0);
    rd_chk("R10 late byte dropped", 4'd2, 16'h00AA);
    idle_all();
  endtask

  task automatic t_precharge();
    open_row(4'd9);
    we_ni = 1'b0; dq_i = 16'h0055; addr_i = 4'd1; casl_ni = 1'b0; tick();
    casl_ni = 1'b1; we_ni = 1'b1; tick();
    oe_ni = 1'b1; cash_ni = 1'b0; addr_i = 4'd1; tick();
    we_ni = 1'b0; dq_i = 16'h6600; tick();
    chk("R11 no err", {15'd0, mix_err_o}, 16'h0);
    release_cas();
    rd_chk("R11 both bytes", 4'd1, 16'h6655);
    idle_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_early();
    t_late();
    t_rmw_blocked();
    t_hold();
    t_oe_toggle();
    t_page();
    t_mixed();
    t_precharge();
    summary();
    $finish;
  end
endmodule